// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage

This block takes the place of an ordinary pipeline register in a latency-insensitive design. It sits between an upstream channel and a downstream channel. Each channel carries data, a valid signal that travels with the data, and a stall signal that the receiver drives back. A token crosses a channel in a cycle only when valid is high and stall is low. Because the stage has two storage slots, it can take a new token in the same cycle that the downstream side first stalls. The extra slot holds that token, so the upstream side sees back-pressure one cycle later.

A controller tracks how many tokens are held: none (Empty), one (Half) or two (Full). The controller drives valid toward the receiver and stall toward the sender. Data always leaves from a head slot. A second slot catches the token that arrives while the head is blocked. A reset parameter chooses whether the stage starts Empty, or Half with a fixed initial token already presented downstream.

Top module: `elastic_stage`

## Requirements
- R1: Synchronous active-high reset. With the empty start option (the default), `dn_valid` and `up_stall` are 0 after reset. With the holding start option, `dn_valid` is 1, `dn_data` equals the configured initial token and `up_stall` is 0.
- R2: A token is taken from the upstream channel only in a cycle where `up_valid`=1 and `up_stall`=0. A token is handed downstream only in a cycle where `dn_valid`=1 and `dn_stall`=0.
- R3: `dn_valid` is 1 exactly when the stage holds one or two tokens. `dn_data` is then the oldest held token.
- R4: `up_stall` is 1 exactly when the stage holds two tokens. An empty stage never stalls.
- R5: Once `dn_valid`=1 meets `dn_stall`=1, the stage keeps `dn_valid` at 1 and `dn_data` unchanged in the next cycle.
- R6: `up_stall` never rises in the cycle after one where `up_valid`=0 and `up_stall`=0.
- R7: Tokens leave in the order they entered, each exactly once, with no loss and no duplication.
- R8: When a token enters and a token leaves in the same cycle, the number of held tokens is unchanged.
- R9: A token entering an empty stage appears on `dn_data` with `dn_valid`=1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | DATA_W | Data from the sender |
| up_valid | input | 1 | Sender offers a token |
| up_stall | output | 1 | Stage cannot take a token |
| dn_data | output | DATA_W | Oldest held token |
| dn_valid | output | 1 | Stage offers a token |
| dn_stall | input | 1 | Receiver cannot take a token |

## Verification
A wrong occupancy count shows at the ports in the very next cycle. Either `dn_valid` or `up_stall` disagrees with the number of tokens the bench has counted in and out, or the head data differs from the oldest token in the bench's queue. A slot that is loaded from the wrong source, or loaded at the wrong time, shows up when that token reaches the head. The token arrives out of sequence, twice, or never. Since every token carries a running sequence number, this is visible on the first transfer that follows. A controller that drops a token during Retry breaks the hold check one cycle after the stall.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_HALF  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    typedef struct packed {
        logic load_head;
        logic head_from_aux;
        logic load_aux;
    } slot_ctl_t;

    function automatic occ_e occ_step(occ_e cur, logic push, logic pop);
        occ_e nxt;
        nxt = cur;
        unique case (cur)
            OCC_EMPTY: if (push) nxt = OCC_HALF;
            OCC_HALF: begin
                if (push && !pop)      nxt = OCC_FULL;
                else if (pop && !push) nxt = OCC_EMPTY;
            end
            OCC_FULL:  if (pop) nxt = OCC_HALF;
            default:   nxt = OCC_EMPTY;
        endcase
        return nxt;
    endfunction

    function automatic slot_ctl_t slot_plan(occ_e cur, logic push, logic pop);
        slot_ctl_t c;
        c.load_head     = ((cur == OCC_EMPTY) && push)
                        || ((cur == OCC_HALF) && push && pop)
                        || ((cur == OCC_FULL) && pop);
        c.head_from_aux = (cur == OCC_FULL);
        c.load_aux      = (cur == OCC_HALF) && push && !pop;
        return c;
    endfunction

endpackage

// File: rtl/elastic_ctrl.sv
module elastic_ctrl
    import elastic_pkg::*;
#(
    parameter bit RESET_HOLDING = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      up_valid,
    input  logic      dn_stall,
    output logic      up_stall,
    output logic      dn_valid,
    output slot_ctl_t ctl
);

    localparam occ_e RESET_OCC = RESET_HOLDING ? OCC_HALF : OCC_EMPTY;

    occ_e occ;
    logic push;
    logic pop;

    assign up_stall = (occ == OCC_FULL);
    assign dn_valid = (occ != OCC_EMPTY);
    assign push     = up_valid && !up_stall;
    assign pop      = dn_valid && !dn_stall;
    assign ctl      = slot_plan(occ, push, pop);

    always_ff @(posedge clk) begin
        if (rst) occ <= RESET_OCC;
        else     occ <= occ_step(occ, push, pop);
    end

    assert_empty_no_stall_R4: assert property (@(posedge clk) disable iff (rst)
        !dn_valid |-> !up_stall);

    assert_swap_keeps_level_R8: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (dn_valid && (up_stall == $past(up_stall))));

endmodule

// File: rtl/elastic_slots.sv
module elastic_slots
    import elastic_pkg::*;
#(
    parameter int              DATA_W        = 8,
    parameter bit              RESET_HOLDING = 1'b0,
    parameter logic [DATA_W-1:0] RESET_TOKEN = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_ctl_t         ctl,
    input  logic [DATA_W-1:0] up_data,
    output logic [DATA_W-1:0] head_q
);

    localparam logic [DATA_W-1:0] HEAD_INIT = RESET_HOLDING ? RESET_TOKEN : '0;

    logic [DATA_W-1:0] aux_q;
    logic [DATA_W-1:0] head_d;

    assign head_d = ctl.head_from_aux ? aux_q : up_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= HEAD_INIT;
            aux_q  <= '0;
        end else begin
            if (ctl.load_head) head_q <= head_d;
            if (ctl.load_aux)  aux_q  <= up_data;
        end
    end

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage
    import elastic_pkg::*;
#(
    parameter int                DATA_W        = 8,
    parameter bit                RESET_HOLDING = 1'b0,
    parameter logic [DATA_W-1:0] RESET_TOKEN   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_valid,
    output logic              up_stall,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_valid,
    input  logic              dn_stall
);

    slot_ctl_t ctl;

    elastic_ctrl #(
        .RESET_HOLDING(RESET_HOLDING)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .up_valid(up_valid),
        .dn_stall(dn_stall),
        .up_stall(up_stall),
        .dn_valid(dn_valid),
        .ctl     (ctl)
    );

    elastic_slots #(
        .DATA_W       (DATA_W),
        .RESET_HOLDING(RESET_HOLDING),
        .RESET_TOKEN  (RESET_TOKEN)
    ) u_slots (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .up_data(up_data),
        .head_q (dn_data)
    );

    assert_retry_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_stall) |=> (dn_valid && $stable(dn_data)));

    assert_no_idle_stall_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (!up_valid && !up_stall) |=> !up_stall);

    assert_fill_from_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_stall && !dn_valid) |=> (dn_valid && dn_data == $past(up_data)));

    assert_stall_needs_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (!up_stall && !(up_valid && dn_valid && dn_stall)) |=> !up_stall);

endmodule

// File: tb/elastic_stage_bench.sv
module elastic_stage_bench;

    localparam int DW = 8;
    localparam logic [DW-1:0] INIT_TOK = 8'hA5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [DW-1:0] up_data = '0;
    logic up_valid = 1'b0;
    logic dn_stall = 1'b0;
    logic up_stall;
    logic [DW-1:0] dn_data;
    logic dn_valid;

    logic [DW-1:0] h_up_data = '0;
    logic h_up_valid = 1'b0;
    logic h_dn_stall = 1'b1;
    logic h_up_stall;
    logic [DW-1:0] h_dn_data;
    logic h_dn_valid;

    elastic_stage #(.DATA_W(DW)) u_elastic_stage (
        .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid),
        .up_stall(up_stall), .dn_data(dn_data), .dn_valid(dn_valid), .dn_stall(dn_stall)
    );

    elastic_stage #(.DATA_W(DW), .RESET_HOLDING(1'b1), .RESET_TOKEN(INIT_TOK)) u_elastic_stage_hold (
        .clk(clk), .rst(rst), .up_data(h_up_data), .up_valid(h_up_valid),
        .up_stall(h_up_stall), .dn_data(h_dn_data), .dn_valid(h_dn_valid), .dn_stall(h_dn_stall)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic [DW-1:0] q [2];
    int cnt = 0;
    logic [DW-1:0] next_send = 8'd1;
    logic [DW-1:0] next_recv = 8'd1;
    bit done = 0;

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit prev_retry;
        bit prev_idle;
        logic [DW-1:0] prev_data;
        bit push;
        bit pop;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dn_valid == 1'b0, "R1 empty valid", dn_valid, 0);
        check(up_stall == 1'b0, "R1 empty stall", up_stall, 0);
        check(h_dn_valid == 1'b1, "R1 hold valid", h_dn_valid, 1);
        check(h_dn_data == INIT_TOK, "R1 hold data", h_dn_data, INIT_TOK);
        check(h_up_stall == 1'b0, "R1 hold stall", h_up_stall, 0);
        h_dn_stall = 1'b0;
        @(negedge clk);
        check(h_dn_valid == 1'b0, "R2 hold drained", h_dn_valid, 0);

        prev_retry = 0;
        prev_idle = 0;
        prev_data = '0;
        for (int pv = 0; pv < 16; pv++) begin
            for (int ps = 0; ps < 16; ps++) begin
                for (int c = 0; c < 12; c++) begin
                    // observe current state (R3, R4, R5, R6)
                    check(dn_valid == (cnt > 0), "R3 valid vs occupancy", dn_valid, cnt > 0);
                    check(up_stall == (cnt == 2), "R4 stall vs occupancy", up_stall, cnt == 2);
                    if (cnt > 0)
                        check(dn_data == q[0], "R7 head order", dn_data, q[0]);
                    if (prev_retry)
                        check(dn_valid && dn_data == prev_data, "R5 retry hold", dn_data, prev_data);
                    if (prev_idle)
                        check(!up_stall, "R6 no stall after idle", up_stall, 0);
                    // drive next inputs; keep an offered token stable while stalled
                    if (!(up_valid && up_stall)) begin
                        up_valid = pv[c % 4];
                        up_data  = next_send;
                    end
                    dn_stall = ps[(c + 1) % 4];
                    push = up_valid && (cnt < 2);
                    pop  = (cnt > 0) && !dn_stall;
                    prev_retry = (cnt > 0) && dn_stall;
                    prev_data  = dn_data;
                    prev_idle  = !up_valid && (cnt < 2);
                    if (pop) begin
                        check(q[0] == next_recv, "R7 sequence", q[0], next_recv);
                        next_recv = next_recv + 8'd1;
                    end
                    // bench model update
                    if (push && pop && cnt == 1) begin
                        q[0] = up_data;
                    end else if (pop) begin
                        q[0] = q[1];
                        cnt--;
                    end
                    if (push && !(pop && cnt == 1 && q[0] == up_data)) begin
                        if (!(pop && cnt == 1)) begin
                            q[cnt] = up_data;
                            cnt++;
                        end
                    end
                    if (push) next_send = next_send + 8'd1;
                    @(negedge clk);
                    if (push && pop && (cnt == 1))
                        check(dn_valid && !up_stall, "R8 swap keeps level", up_stall, 0);
                end
            end
        end
        // drain and check nothing lost (R7, R9)
        up_valid = 1'b0;
        dn_stall = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(next_recv + 8'(cnt) == next_send || cnt == 0, "R7 no loss", next_recv, next_send);
        check(!dn_valid, "R3 drained", dn_valid, 0);
        up_valid = 1'b1;
        up_data = 8'h3C;
        dn_stall = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
        check(dn_valid && dn_data == 8'h3C, "R9 fill from empty", dn_data, 8'h3C);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule